// File: doc/BRIEF.md
# MDIO Management Master with Background PHY Polling

This block is a management-bus master for Ethernet PHYs. It derives the MDC clock from the system clock through a programmable divider. It runs single read or write frames that software requests through a user-access register. Software reaches the block over a simple word-addressed register port: an address, a write strobe, write data, and read data that is returned one clock after the address.

While polling is enabled, a background engine reads the status register (register 1) of every PHY address in ascending order and wraps round after the last one. Each poll updates one bit in two bitmasks. The alive mask tells software which addresses answer. The link mask holds each answering PHY's link-up bit, which is bit 2 of its status word.

Software requests and the poller share the one MDIO wire. A pending request never cuts into a frame that is already running. It goes out immediately after that frame and ahead of the next poll. An idle flag lets software see when polling has been switched off and the wire has gone quiet.

Top module: `mdio_poll_ctrl`

## Requirements
- R1: The MDC period is max(D,1)+1 system clock cycles, where D is the 8-bit divider in control bits 7:0. D = 0 acts as 1. The divider resets to 9.
- R2: Control word (word address 0): bit 30 is the polling enable (read/write, reset 0) and bits 7:0 hold the divider. Bit 31 is a read-only idle flag. It reads 1 only when polling is off, no frame is running and no user request is pending.
- R3: Each frame is sent MSB first and is driven after a falling MDC edge. It consists of 32 ones, then start bits 01, then an opcode (10 for read, 01 for write), then the 5-bit PHY address and the 5-bit register address. A write frame continues with turnaround 10 and 16 data bits. A read frame releases output-enable for the last 18 bit times.
- R4: User-access word (word address 3): bit 31 GO, bit 30 write(1)/read(0), bit 29 ACK, bits 25:21 register address, bits 20:16 PHY address, bits 15:0 data. Writing it with GO set starts a frame. GO stays 1 until that frame finishes and then clears by itself.
- R5: After a user read, bits 15:0 hold the 16 bits sampled on rising MDC edges after the turnaround. ACK is 1 only if the second turnaround bit was sampled low. After a user write, ACK is 0 and the data field keeps the written value.
- R6: A write to the user-access word while GO is 1 is ignored: no frame is sent for it and no field changes.
- R7: While enabled, the poller reads register 1 of PHY addresses 0 to 31 in ascending order, wrapping round. After each poll, bit n of the alive word (word address 1) is set if PHY n acknowledged and cleared if it did not.
- R8: After each poll, bit n of the link word (word address 2) holds bit 2 of the returned status if PHY n acknowledged, and 0 otherwise.
- R9: A user request that is raised during a frame starts right after that frame and ahead of any further poll.
- R10: Clearing the enable lets the current frame finish and starts no further polls. The alive and link words keep their values, and the idle flag then reads 1.
- R11: Read data appears one clock after the address is presented. Word addresses other than 0 to 3 read as zero. After reset, the control word reads 0x80000009 and the alive, link and user-access words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after address |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pin |

## Verification
The hardest case to reach from the ports is a user request that lands inside a poll frame, before that frame's header has gone out. Only then does the request have to wait a full frame and still win against the next poll. The bench includes a PHY model that logs each frame header it decodes. The bench waits until a poll header has just been logged, lets that frame end and the next preamble start, and only then writes GO. It also writes a second, conflicting request while GO is still set. From the frame log it then confirms that the user frame came right after the frame in progress, and that the conflicting request never appeared on the wire.

// File: rtl/mdio_poll_pkg.sv
package mdio_poll_pkg;
  localparam int FRAME_BITS  = 64;
  localparam int PRE_BITS    = 32;
  localparam int TA_FIRST    = 46;
  localparam int DATA_FIRST  = 48;
  localparam int STAT_REG    = 1;
  localparam int LINK_BIT    = 2;
  localparam int CTL_IDLE_BIT = 31;
  localparam int CTL_EN_BIT   = 30;
  localparam int UA_GO_BIT    = 31;
  localparam int UA_WR_BIT    = 30;
  localparam int UA_ACK_BIT   = 29;

  typedef enum logic [1:0] {
    OP_WR = 2'b01,
    OP_RD = 2'b10
  } mdio_op_e;

  typedef struct packed {
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] data;
  } mdio_req_t;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic [DIV_W:0]   lim_p1;
  logic [DIV_W-1:0] half;

  always_comb begin
    lim      = (div == '0) ? DIV_W'(1) : div;
    lim_p1   = {1'b0, lim} + 1'b1;
    half     = lim_p1[DIV_W:1] - 1'b1;
    rise_evt = (cnt == half);
    fall_evt = (cnt >= lim);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= fall_evt ? '0 : cnt + 1'b1;
      if (rise_evt)      mdc <= 1'b1;
      else if (fall_evt) mdc <= 1'b0;
    end
  end

  AST_MDC_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!rise_evt && !fall_evt) |=> $stable(mdc)); // R1
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_poll_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rise_evt,
  input  logic        fall_evt,
  input  logic        start,
  input  mdio_req_t   req,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        busy,
  output logic        done,
  output logic        ack,
  output logic [15:0] rd_data
);
  localparam int IDX_W = $clog2(FRAME_BITS);

  logic                  active;
  logic                  is_wr;
  logic [IDX_W-1:0]      idx;
  logic [FRAME_BITS-1:0] sh;

  function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_req_t r);
    mdio_op_e op;
    op = r.wr ? OP_WR : OP_RD;
    build_frame = {{PRE_BITS{1'b1}}, 2'b01, op, r.phy, r.regad,
                   (r.wr ? 2'b10 : 2'b11), (r.wr ? r.data : 16'hFFFF)};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      is_wr   <= 1'b0;
      mdio_oe <= 1'b0;
      mdio_o  <= 1'b1;
      idx     <= '0;
      sh      <= '0;
      ack     <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy   <= 1'b1;
        active <= 1'b0;
        is_wr  <= req.wr;
        sh     <= build_frame(req);
        ack    <= 1'b0;
      end else if (busy && fall_evt) begin
        if (!active) begin
          active  <= 1'b1;
          idx     <= '0;
          mdio_o  <= sh[FRAME_BITS-1];
          mdio_oe <= 1'b1;
          sh      <= {sh[FRAME_BITS-2:0], 1'b0};
        end else if (idx == IDX_W'(FRAME_BITS-1)) begin
          active  <= 1'b0;
          busy    <= 1'b0;
          done    <= 1'b1;
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b1;
        end else begin
          idx     <= idx + 1'b1;
          mdio_o  <= sh[FRAME_BITS-1];
          mdio_oe <= is_wr || (idx < IDX_W'(TA_FIRST-1));
          sh      <= {sh[FRAME_BITS-2:0], 1'b0};
        end
      end
      if (busy && active && rise_evt && !is_wr) begin
        if (idx == IDX_W'(TA_FIRST+1)) ack <= !mdio_i;
        if (idx >= IDX_W'(DATA_FIRST)) rd_data <= {rd_data[14:0], mdio_i};
      end
    end
  end

  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (active && !is_wr && idx >= IDX_W'(TA_FIRST)) |-> !mdio_oe); // R3
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R4
  AST_DONE_FREE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !mdio_oe)); // R4
endmodule

// File: rtl/mdio_poll_ctrl.sv
module mdio_poll_ctrl
  import mdio_poll_pkg::*;
#(
  parameter int NPHY     = 32,
  parameter int REG_AW   = 4,
  parameter int DIV_W    = 8,
  parameter int DIV_INIT = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int SCAN_W = $clog2(NPHY);
  localparam logic [REG_AW-1:0] A_CTL   = REG_AW'(0);
  localparam logic [REG_AW-1:0] A_ALIVE = REG_AW'(1);
  localparam logic [REG_AW-1:0] A_LINK  = REG_AW'(2);
  localparam logic [REG_AW-1:0] A_USER  = REG_AW'(3);

  logic              en;
  logic [DIV_W-1:0]  div;
  logic [NPHY-1:0]   alive, link;
  logic              go, ua_wr, ua_ack;
  logic [4:0]        ua_reg, ua_phy;
  logic [15:0]       ua_data;
  logic [SCAN_W-1:0] scan_ptr;
  logic              owner_user;

  logic              rise_evt, fall_evt;
  logic              eng_busy, eng_done, eng_ack;
  logic [15:0]       eng_rd;
  logic              can_start, start_user, start_scan, eng_start, idle;
  mdio_req_t         eng_req;
  logic [31:0]       ctl_word, alive_word, link_word, user_word;

  mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .div(div),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_frame_eng u_eng (
    .clk(clk), .rst(rst), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .start(eng_start), .req(eng_req), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(eng_busy), .done(eng_done),
    .ack(eng_ack), .rd_data(eng_rd)
  );

  always_comb begin
    can_start  = !eng_busy && !eng_done;
    start_user = can_start && go;
    start_scan = can_start && !go && en;
    eng_start  = start_user || start_scan;
    idle       = !en && !eng_busy && !go;
    eng_req    = '0;
    if (start_user) begin
      eng_req.wr    = ua_wr;
      eng_req.phy   = ua_phy;
      eng_req.regad = ua_reg;
      eng_req.data  = ua_data;
    end else begin
      eng_req.phy   = 5'(scan_ptr);
      eng_req.regad = 5'(STAT_REG);
    end
  end

  always_comb begin
    ctl_word = '0;
    ctl_word[CTL_IDLE_BIT] = idle;
    ctl_word[CTL_EN_BIT]   = en;
    ctl_word[DIV_W-1:0]    = div;
    alive_word = '0;
    alive_word[NPHY-1:0] = alive;
    link_word = '0;
    link_word[NPHY-1:0] = link;
    user_word = {go, ua_wr, ua_ack, 3'b000, ua_reg, ua_phy, ua_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en         <= 1'b0;
      div        <= DIV_W'(DIV_INIT);
      alive      <= '0;
      link       <= '0;
      go         <= 1'b0;
      ua_wr      <= 1'b0;
      ua_ack     <= 1'b0;
      ua_reg     <= '0;
      ua_phy     <= '0;
      ua_data    <= '0;
      scan_ptr   <= '0;
      owner_user <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      if (eng_start) owner_user <= start_user;
      if (eng_done) begin
        if (owner_user) begin
          go     <= 1'b0;
          ua_ack <= eng_ack;
          if (!ua_wr) ua_data <= eng_rd;
        end else begin
          alive[scan_ptr] <= eng_ack;
          link[scan_ptr]  <= eng_ack && eng_rd[LINK_BIT];
          scan_ptr <= (scan_ptr == SCAN_W'(NPHY-1)) ? '0 : scan_ptr + 1'b1;
        end
      end
      if (reg_we) begin
        if (reg_addr == A_CTL) begin
          en  <= reg_wdata[CTL_EN_BIT];
          div <= reg_wdata[DIV_W-1:0];
        end else if (reg_addr == A_USER && !go) begin
          go      <= reg_wdata[UA_GO_BIT];
          ua_wr   <= reg_wdata[UA_WR_BIT];
          ua_ack  <= 1'b0;
          ua_reg  <= reg_wdata[25:21];
          ua_phy  <= reg_wdata[20:16];
          ua_data <= reg_wdata[15:0];
        end
      end
      case (reg_addr)
        A_CTL:   reg_rdata <= ctl_word;
        A_ALIVE: reg_rdata <= alive_word;
        A_LINK:  reg_rdata <= link_word;
        A_USER:  reg_rdata <= user_word;
        default: reg_rdata <= '0;
      endcase
    end
  end

  AST_GO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (go && !(eng_done && owner_user)) |=> go); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!en && !go && !eng_busy) |-> !mdio_oe); // R10
  AST_USER_NEXT: assert property (@(posedge clk) disable iff (rst)
    (eng_done && !owner_user && go) |=> ##1 (eng_busy && owner_user)); // R9
  AST_NO_SCAN_OFF: assert property (@(posedge clk) disable iff (rst)
    (eng_start && !en) |-> start_user); // R10
endmodule

// File: tb/mdio_poll_ctrl_test.sv
module mdio_poll_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i;

  always #10 clk = ~clk;

  mdio_poll_ctrl uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- PHY model ----------------
  logic [31:0] phy_alive = 32'h8104_2C09;
  logic [31:0] phy_link  = 32'h0100_2809;
  logic [15:0] pmem [0:1023];
  int          nfr = 0;
  logic [1:0]  log_op  [0:255];
  logic [4:0]  log_phy [0:255];
  logic [4:0]  log_reg [0:255];
  logic [15:0] last_wdata = '0;
  int          ta_bad = 0;

  function automatic logic [15:0] phy_val(input logic [4:0] p, input logic [4:0] r);
    if (r == 5'd1) return 16'h7849 | (phy_link[p] ? 16'h0004 : 16'h0000);
    return pmem[{p, r}];
  endfunction

  initial begin
    for (int i = 0; i < 1024; i++) pmem[i] = 16'(i * 613) ^ 16'h5A3C;
  end

  initial begin : phy_model
    int          ones;
    logic        b;
    logic [12:0] hdr;
    logic [15:0] v;
    logic [15:0] wd;
    logic [1:0]  ta;
    ones = 0;
    mdio_i = 1'b1;
    forever begin
      @(posedge mdc);
      b = mdio_oe ? mdio_o : 1'b1;
      if (b) ones++;
      else if (ones >= 32) begin
        hdr = '0;
        for (int k = 0; k < 13; k++) begin
          @(posedge mdc);
          hdr = {hdr[11:0], (mdio_oe ? mdio_o : 1'b1)};
        end
        log_op[nfr % 256]  = hdr[11:10];
        log_phy[nfr % 256] = hdr[9:5];
        log_reg[nfr % 256] = hdr[4:0];
        nfr++;
        if (hdr[11:10] == 2'b10) begin
          if (phy_alive[hdr[9:5]]) begin
            v = phy_val(hdr[9:5], hdr[4:0]);
            for (int t = 0; t < 18; t++) begin
              @(negedge mdc);
              mdio_i = (t == 0) ? 1'b1 : (t == 1) ? 1'b0 : v[17-t];
            end
            @(negedge mdc);
            mdio_i = 1'b1;
          end
        end else begin
          wd = '0;
          ta = '0;
          for (int t = 0; t < 18; t++) begin
            @(posedge mdc);
            wd = {wd[14:0], (mdio_oe ? mdio_o : 1'b1)};
            if (t == 1) ta = wd[1:0];
          end
          if (ta != 2'b10) ta_bad++;
          last_wdata = wd;
          if (phy_alive[hdr[9:5]] && hdr[4:0] != 5'd1) pmem[{hdr[9:5], hdr[4:0]}] = wd;
        end
        ones = 0;
      end else ones = 0;
    end
  end

  logic oe_seen = 1'b0;
  always @(posedge clk) if (mdio_oe) oe_seen <= 1'b1;

  // ---------------- bus tasks ----------------
  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic logic [31:0] ua_word(input logic g, input logic w, input logic [4:0] r,
                                          input logic [4:0] p, input logic [15:0] d);
    return {g, w, 1'b0, 3'b000, r, p, d};
  endfunction

  task automatic wait_go(output logic [31:0] d);
    int n;
    n = 0;
    do begin reg_rd(4'd3, d); n++; end while (d[31] && n < 20000);
  endtask

  task automatic wait_frames(input int n);
    int tgt, g;
    tgt = nfr + n; g = 0;
    while (nfr < tgt && g < 60000) begin @(posedge clk); g++; end
  endtask

  task automatic mdc_period(output int p);
    logic pm;
    @(posedge mdc);
    @(negedge clk);
    p = 0; pm = mdc;
    forever begin
      @(negedge clk);
      p++;
      if ((mdc && !pm) || p > 2000) break;
      pm = mdc;
    end
  endtask

  task automatic user_op(input logic w, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    logic [31:0] res, exp;
    logic        a;
    reg_wr(4'd3, ua_word(1'b1, w, r, p, d));
    wait_go(res);
    a = phy_alive[p];
    if (w) begin
      exp = {1'b0, 1'b1, 1'b0, 3'b000, r, p, d};
      chk("R5 write result word", res, exp);
      chk("R3 write data on wire", 32'(last_wdata), 32'(d));
    end else begin
      exp = {1'b0, 1'b0, a, 3'b000, r, p, (a ? phy_val(p, r) : 16'hFFFF)};
      chk("R5 read result word", res, exp);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    logic [31:0] d;
    int          p, n0, k, nwr, bad, nfr_off;
    logic [31:0] alive_off;
    void'($urandom(32'd7715));

    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R11 reset state
    reg_rd(4'd0, d); chk("R11 reset control", d, 32'h8000_0009);
    reg_rd(4'd1, d); chk("R11 reset alive", d, 32'h0);
    reg_rd(4'd2, d); chk("R11 reset link", d, 32'h0);
    reg_rd(4'd3, d); chk("R11 reset user word", d, 32'h0);
    reg_rd(4'd9, d); chk("R11 unmapped address", d, 32'h0);
    chk("R2 no drive after reset", 32'(mdio_oe), 32'h0);

    // R1 divider
    mdc_period(p); chk("R1 period div=9", p, 10);
    reg_wr(4'd0, 32'h0000_0000); mdc_period(p); mdc_period(p); chk("R1 period div=0", p, 2);
    reg_wr(4'd0, 32'h0000_0004); mdc_period(p); mdc_period(p); chk("R1 period div=4", p, 5);
    reg_wr(4'd0, 32'h0000_00FF); mdc_period(p); mdc_period(p); chk("R1 period div=255", p, 256);

    // R7 / R8 polling
    reg_wr(4'd0, 32'h4000_0001);
    reg_rd(4'd0, d); chk("R2 control while enabled", d, 32'h4000_0001);
    wait_frames(35);
    reg_rd(4'd1, d); chk("R7 alive mask", d, phy_alive);
    reg_rd(4'd2, d); chk("R8 link mask", d, phy_alive & phy_link);
    bad = 0;
    for (int i = nfr - 33; i < nfr - 1; i++) begin
      if (log_phy[(i+1) % 256] != 5'(log_phy[i % 256] + 5'd1)) bad++;
      if (log_reg[i % 256] != 5'd1 || log_op[i % 256] != 2'b10) bad++;
    end
    chk("R7 ascending status polls", bad, 0);

    // change the PHY population and link states
    phy_alive = phy_alive & ~32'h0000_0008;
    phy_link  = phy_link ^ 32'h8000_0400;
    wait_frames(35);
    reg_rd(4'd1, d); chk("R7 alive after PHY loss", d, phy_alive);
    reg_rd(4'd2, d); chk("R8 link after change", d, phy_alive & phy_link);

    // R9 / R6 / R4: request raised during a poll frame
    n0 = nfr;
    while (nfr == n0) @(posedge clk);
    repeat (60) @(posedge clk);
    n0 = nfr;
    reg_wr(4'd3, ua_word(1'b1, 1'b0, 5'd3, 5'd0, 16'h0000));
    reg_rd(4'd3, d); chk("R4 GO held while pending", 32'(d[31]), 32'h1);
    reg_wr(4'd3, ua_word(1'b1, 1'b1, 5'd7, 5'd31, 16'hBEEF));
    wait_go(d);
    chk("R6 fields kept, R5 read data", d,
        {1'b0, 1'b0, 1'b1, 3'b000, 5'd3, 5'd0, phy_val(5'd0, 5'd3)});
    k = -1; nwr = 0;
    for (int i = n0; i < nfr; i++) begin
      if (k < 0 && log_op[i % 256] == 2'b10 && log_phy[i % 256] == 5'd0 && log_reg[i % 256] == 5'd3) k = i;
      if (log_op[i % 256] == 2'b01) nwr++;
    end
    chk("R9 user frame follows current frame", 32'(k >= n0 && k <= n0 + 1), 32'h1);
    chk("R6 ignored request never sent", nwr, 0);

    // R5 dead PHY, write then read back
    user_op(1'b0, 5'd5, 5'd2, 16'h0000);
    user_op(1'b1, 5'd31, 5'd4, 16'hA5C3);
    user_op(1'b0, 5'd31, 5'd4, 16'h0000);
    user_op(1'b0, 5'd24, 5'd1, 16'h0000);

    // random accesses
    for (int i = 0; i < 14; i++) begin
      logic w;
      logic [4:0] pp, rr;
      logic [15:0] dd;
      w  = 1'($urandom_range(0, 1));
      pp = 5'($urandom_range(0, 31));
      rr = 5'($urandom_range(0, 31));
      dd = 16'($urandom);
      user_op(w, pp, rr, dd);
    end

    // R10 disable polling
    reg_wr(4'd0, 32'h0000_0001);
    k = 0;
    do begin reg_rd(4'd0, d); k++; end while (!d[31] && k < 400);
    chk("R10 idle after disable", d, 32'h8000_0001);
    reg_rd(4'd1, alive_off);
    nfr_off = nfr;
    @(negedge clk) oe_seen = 1'b0;
    repeat (800) @(posedge clk);
    chk("R10 no frames while disabled", nfr - nfr_off, 0);
    chk("R10 wire quiet while disabled", 32'(oe_seen), 32'h0);
    reg_rd(4'd1, d); chk("R10 alive held", d, alive_off);
    reg_rd(4'd2, d); chk("R10 link held", d, phy_alive & phy_link);
    user_op(1'b0, 5'd13, 5'd9, 16'h0000);
    chk("R3 write turnaround 10", ta_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule